// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the bus writes that a host issues to a parallel flash array and recognises the multi-cycle command sequences that start embedded operations. A recognised word program, chip-wide erase or sector erase becomes a one-cycle request to the erase/program engine, together with the captured address and data. The engine stays outside this block and reports through a busy input. While busy is high, the decoder ignores all host writes.

Besides the standard sequences, the decoder has a fast programming mode. A three-write entry sequence turns it on. In this mode each word needs only a command write and a data write. Every other command is ignored until a two-write exit sequence returns the decoder to read-array mode. The current mode is always visible on an output.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset (`rst_ni` low) the decoder is in read-array mode (`bypass_o`=0), its sequence is cleared and no request output is high.
- R2: A standard program is the write sequence AAh@555h, 55h@2AAh, A0h, then a target write. The cycle after the target write is accepted, `prog_req_o` is high with `prog_addr_o`/`prog_data_o` equal to that write's address and data.
- R3: Command matching uses only data bits [7:0]. Unlock writes match on address bits [10:0] only. Command writes other than the unlock writes have a don't-care address.
- R4: The write sequence AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, 10h raises `bulk_erase_o` in the cycle after the sixth write.
- R5: The same sequence with 30h as its sixth write raises `sect_erase_o` instead. `sect_addr_o` then carries the sixth write's address bits [ADDR_W-1:ADDR_W-SECT_W].
- R6: In read-array mode, a write that does not match the next expected step of a sequence abandons the sequence with no request. F0h is one such write. The following writes then must start again from the first unlock write.
- R7: The write sequence AAh@555h, 55h@2AAh, 20h sets `bypass_o` to 1 in the cycle after the third write.
- R8: In bypass mode, an A0h write followed by a target write raises `prog_req_o` with that target's address and data. The pair may repeat any number of times.
- R9: In bypass mode, any write that is neither A0h nor 90h in command position is ignored. It produces no request, leaves `bypass_o` at 1 and does not disturb a following A0h/target pair.
- R10: In bypass mode, a 90h write followed by a 00h write clears `bypass_o`. Addresses are ignored on both writes. If the write after 90h is not 00h, the decoder stays in bypass mode.
- R11: A write presented while `busy_i` is high is ignored. It raises no request and leaves a sequence in progress where it was.
- R12: Each request output is high for exactly one cycle per accepted sequence, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | DATA_W | Host write data |
| busy_i | input | 1 | Erase/program engine busy |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | ADDR_W | Address to program |
| prog_data_o | output | DATA_W | Data to program |
| bulk_erase_o | output | 1 | Whole-array erase request pulse |
| sect_erase_o | output | 1 | Sector erase request pulse |
| sect_addr_o | output | SECT_W | Sector to erase |
| bypass_o | output | 1 | 1 = fast programming mode, 0 = read array |

## Verification
Programs are issued through both the standard four-write sequence and the two-write fast-mode sequence. The targets are random, and the command writes carry random upper data bytes and high address bits, which shows that only the specified bits are compared. Broken sequences are tested with a wrong byte at different steps and with F0h. Each is followed by the rest of a valid sequence, which shows that a sequence is abandoned rather than merely paused. Writes made while busy is high, placed in the middle of a sequence, show the difference between ignoring a write and aborting on it. In fast mode, foreign commands placed before a program pair show the difference between an ignored command and one that changes the mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UL1,
    ST_UL2,
    ST_PGM,
    ST_ER3,
    ST_ER4,
    ST_ER5,
    ST_BYP,
    ST_BYP_PGM,
    ST_BYP_RST
  } fcd_state_e;

  typedef struct packed {
    logic ul1;
    logic ul2;
    logic pgm;
    logic ers;
    logic bulk;
    logic sect;
    logic byp;
    logic brst;
    logic brst_end;
  } fcd_hit_t;

  localparam logic [7:0] CMD_UL1      = 8'hAA;
  localparam logic [7:0] CMD_UL2      = 8'h55;
  localparam logic [7:0] CMD_PGM      = 8'hA0;
  localparam logic [7:0] CMD_ERS      = 8'h80;
  localparam logic [7:0] CMD_BULK     = 8'h10;
  localparam logic [7:0] CMD_SECT     = 8'h30;
  localparam logic [7:0] CMD_BYP      = 8'h20;
  localparam logic [7:0] CMD_BRST     = 8'h90;
  localparam logic [7:0] CMD_BRST_END = 8'h00;

  localparam int unsigned UL1_ADDR = 32'h555;
  localparam int unsigned UL2_ADDR = 32'h2AA;

endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ULK_W  = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output fcd_hit_t          hit_o
);

  localparam logic [ULK_W-1:0] A1 = ULK_W'(UL1_ADDR);
  localparam logic [ULK_W-1:0] A2 = ULK_W'(UL2_ADDR);

  logic [ULK_W-1:0] a_lo;
  logic [7:0]       cmd;

  assign a_lo = addr_i[ULK_W-1:0];

  // command byte is the low data byte regardless of bus width
  generate
    if (DATA_W >= 8) begin : g_wide
      assign cmd = data_i[7:0];
    end else begin : g_narrow
      assign cmd = 8'(data_i);
    end
  endgenerate

  always_comb begin
    hit_o          = '0;
    hit_o.ul1      = (cmd == CMD_UL1) && (a_lo == A1);
    hit_o.ul2      = (cmd == CMD_UL2) && (a_lo == A2);
    hit_o.pgm      = (cmd == CMD_PGM);
    hit_o.ers      = (cmd == CMD_ERS);
    hit_o.bulk     = (cmd == CMD_BULK);
    hit_o.sect     = (cmd == CMD_SECT);
    hit_o.byp      = (cmd == CMD_BYP);
    hit_o.brst     = (cmd == CMD_BRST);
    hit_o.brst_end = (cmd == CMD_BRST_END);
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       busy_i,
  input  fcd_hit_t   hit_i,
  output fcd_state_e state_o,
  output logic       fire_prog_o,
  output logic       fire_bulk_o,
  output logic       fire_sect_o
);

  fcd_state_e state_q, state_d;
  logic       accept;

  assign accept = wr_en_i && !busy_i;

  always_comb begin
    state_d     = state_q;
    fire_prog_o = 1'b0;
    fire_bulk_o = 1'b0;
    fire_sect_o = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_READ: state_d = hit_i.ul1 ? ST_UL1 : ST_READ;
        ST_UL1:  state_d = hit_i.ul2 ? ST_UL2 : ST_READ;
        ST_UL2: begin
          if (hit_i.pgm)      state_d = ST_PGM;
          else if (hit_i.ers) state_d = ST_ER3;
          else if (hit_i.byp) state_d = ST_BYP;
          else                state_d = ST_READ;
        end
        ST_PGM: begin
          fire_prog_o = 1'b1;
          state_d     = ST_READ;
        end
        ST_ER3: state_d = hit_i.ul1 ? ST_ER4 : ST_READ;
        ST_ER4: state_d = hit_i.ul2 ? ST_ER5 : ST_READ;
        ST_ER5: begin
          fire_bulk_o = hit_i.bulk;
          fire_sect_o = hit_i.sect;
          state_d     = ST_READ;
        end
        ST_BYP: begin
          // foreign commands leave the mode untouched
          if (hit_i.pgm)       state_d = ST_BYP_PGM;
          else if (hit_i.brst) state_d = ST_BYP_RST;
          else                 state_d = ST_BYP;
        end
        ST_BYP_PGM: begin
          fire_prog_o = 1'b1;
          state_d     = ST_BYP;
        end
        ST_BYP_RST: state_d = hit_i.brst_end ? ST_READ : ST_BYP;
        default:    state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_READ;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_q));

  assert_byp_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYP && accept && !hit_i.pgm && !hit_i.brst) |=> state_q == ST_BYP);

  assert_byp_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYP_RST && accept && hit_i.brst_end) |=> state_q == ST_READ);

  assert_byp_enter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UL2 && accept && hit_i.byp) |=> state_q == ST_BYP);

endmodule

// File: rtl/fcd_req_out.sv
module fcd_req_out #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SECT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_prog_i,
  input  logic              fire_bulk_i,
  input  logic              fire_sect_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              bulk_erase_o,
  output logic              sect_erase_o,
  output logic [SECT_W-1:0] sect_addr_o
);

  localparam int unsigned SECT_LSB = ADDR_W - SECT_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o   <= 1'b0;
      bulk_erase_o <= 1'b0;
      sect_erase_o <= 1'b0;
    end else begin
      prog_req_o   <= fire_prog_i;
      bulk_erase_o <= fire_bulk_i;
      sect_erase_o <= fire_sect_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_addr_o <= '0;
      prog_data_o <= '0;
      sect_addr_o <= '0;
    end else begin
      if (fire_prog_i) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
      end
      if (fire_sect_i) sect_addr_o <= addr_i[ADDR_W-1:SECT_LSB];
    end
  end

  assert_req_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, bulk_erase_o, sect_erase_o}));

  assert_prog_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);

  assert_erase_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bulk_erase_o || sect_erase_o) |=> !(bulk_erase_o || sect_erase_o));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ULK_W  = 11,
  parameter int unsigned SECT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              bulk_erase_o,
  output logic              sect_erase_o,
  output logic [SECT_W-1:0] sect_addr_o,
  output logic              bypass_o
);

  fcd_hit_t   hit;
  fcd_state_e state;
  logic       fire_prog, fire_bulk, fire_sect;

  fcd_cmd_match #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ULK_W (ULK_W)
  ) i_match (
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .hit_o (hit)
  );

  fcd_seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .busy_i     (busy_i),
    .hit_i      (hit),
    .state_o    (state),
    .fire_prog_o(fire_prog),
    .fire_bulk_o(fire_bulk),
    .fire_sect_o(fire_sect)
  );

  fcd_req_out #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SECT_W(SECT_W)
  ) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_prog_i (fire_prog),
    .fire_bulk_i (fire_bulk),
    .fire_sect_i (fire_sect),
    .addr_i      (wr_addr_i),
    .data_i      (wr_data_i),
    .prog_req_o  (prog_req_o),
    .prog_addr_o (prog_addr_o),
    .prog_data_o (prog_data_o),
    .bulk_erase_o(bulk_erase_o),
    .sect_erase_o(sect_erase_o),
    .sect_addr_o (sect_addr_o)
  );

  assign bypass_o = (state == ST_BYP) || (state == ST_BYP_PGM) || (state == ST_BYP_RST);

  assert_no_erase_in_byp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |=> !(bulk_erase_o || sect_erase_o));

  assert_busy_no_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_req_o || bulk_erase_o || sect_erase_o));

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          prog_req, bulk_er, sect_er, byp;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [SW-1:0] sect_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .ULK_W(11), .SECT_W(SW)) i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .prog_req_o(prog_req),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .bulk_erase_o(bulk_er),
    .sect_erase_o(sect_er), .sect_addr_o(sect_addr), .bypass_o(byp)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // random upper byte: only the low byte is a command
  function automatic logic [DW-1:0] cmd(input logic [7:0] c);
    return {8'($urandom()), c};
  endfunction

  function automatic logic [AW-1:0] ul_addr(input logic [10:0] lo);
    return {9'($urandom()), lo};
  endfunction

  // one write: drive at negedge, outputs sampled at the next negedge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(ul_addr(11'h555), cmd(8'hAA));
    wr(ul_addr(11'h2AA), cmd(8'h55));
  endtask

  function automatic bit no_req();
    return !prog_req && !bulk_er && !sect_er;
  endfunction

  task automatic chk_prog(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(prog_req === 1'b1, {tag, " prog_req"}, 32'(prog_req), 1);
    chk(prog_addr === a, {tag, " prog_addr"}, 32'(prog_addr), 32'(a));
    chk(prog_data === d, {tag, " prog_data"}, 32'(prog_data), 32'(d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(no_req() && !byp, "R1 reset state", {prog_req, bulk_er, sect_er, byp}, 0);
    rst_ni = 1'b1;
    idle();
    chk(no_req() && !byp, "R1 after release", {prog_req, bulk_er, sect_er, byp}, 0);

    // R2 standard program
    unlock();
    wr(20'h00123, cmd(8'hA0));
    wr(20'h12345, 16'hBEEF);
    chk_prog("R2 std", 20'h12345, 16'hBEEF);
    idle();
    chk(!prog_req, "R12 prog pulse width", 32'(prog_req), 0);

    // R3 unlock needs low 11 address bits
    wr(20'h00455, cmd(8'hAA));
    wr(20'h002AA, cmd(8'h55));
    wr(20'h00000, cmd(8'hA0));
    wr(20'h00100, 16'h1234);
    chk(no_req(), "R3 bad unlock addr", 32'(prog_req), 0);
    wr(20'hF8555, 16'h5AAA);
    wr(20'h7F2AA, 16'hC355);
    wr(20'h3C000, 16'h77A0);
    wr(20'h0ABCD, 16'h0F0F);
    chk_prog("R3 high bits ignored", 20'h0ABCD, 16'h0F0F);

    // R4 bulk erase
    unlock(); wr(20'h0, cmd(8'h80)); unlock();
    wr(20'h0, cmd(8'h10));
    chk(bulk_er === 1'b1 && !prog_req && !sect_er, "R4 bulk erase", {bulk_er, sect_er}, 2'b10);
    idle();
    chk(!bulk_er, "R12 bulk pulse width", 32'(bulk_er), 0);

    // R5 sector erase
    unlock(); wr(20'h0, cmd(8'h80)); unlock();
    wr(20'hA1234, cmd(8'h30));
    chk(sect_er === 1'b1 && !bulk_er, "R5 sector erase", {bulk_er, sect_er}, 2'b01);
    chk(sect_addr === 4'hA, "R5 sector addr", 32'(sect_addr), 32'hA);

    // R6 abort on wrong step, then the remainder must not fire
    unlock(); wr(20'h0, cmd(8'h80)); unlock();
    wr(20'h0, cmd(8'h77));
    wr(20'h0, cmd(8'h10));
    chk(no_req(), "R6 wrong sixth write", {prog_req, bulk_er, sect_er}, 0);
    unlock(); wr(20'h0, cmd(8'hF0));
    wr(20'h0, cmd(8'hA0));
    wr(20'h00200, 16'h1111);
    chk(no_req(), "R6 F0 aborts program", 32'(prog_req), 0);
    unlock(); wr(20'h0, cmd(8'h80));
    wr(20'h00555, cmd(8'h55));
    unlock(); wr(20'h0, cmd(8'h10));
    chk(no_req(), "R6 wrong third unlock", 32'(bulk_er), 0);
    chk(!byp, "R6 still read array", 32'(byp), 0);

    // R11 busy writes ignored mid-sequence
    unlock();
    busy = 1'b1; wr(20'h0, cmd(8'h77)); busy = 1'b0;
    wr(20'h0, cmd(8'hA0));
    busy = 1'b1; wr(20'h00300, 16'h2222); busy = 1'b0;
    chk(no_req(), "R11 busy target ignored", 32'(prog_req), 0);
    wr(20'h00301, 16'h3333);
    chk_prog("R11 sequence resumes", 20'h00301, 16'h3333);

    // R7 bypass entry
    unlock();
    wr(20'h0, cmd(8'h20));
    chk(byp === 1'b1, "R7 bypass entered", 32'(byp), 1);

    // R8 bypass program, random targets
    for (int i = 0; i < 30; i++) begin
      a = AW'($urandom());
      d = DW'($urandom());
      wr(AW'($urandom()), cmd(8'hA0));
      wr(a, d);
      chk_prog("R8 bypass program", a, d);
    end

    // R9 foreign commands ignored in bypass
    wr(20'h0, cmd(8'hF0));
    wr(20'h00555, cmd(8'hAA));
    wr(20'h002AA, cmd(8'h55));
    wr(20'h0, cmd(8'h80));
    wr(20'h0, cmd(8'h10));
    chk(no_req(), "R9 no request from foreign", {prog_req, bulk_er, sect_er}, 0);
    chk(byp === 1'b1, "R9 mode kept", 32'(byp), 1);
    wr(20'h0, cmd(8'hA0));
    wr(20'h44444, 16'h4444);
    chk_prog("R9 program after foreign", 20'h44444, 16'h4444);

    // R10 bad exit keeps mode, good exit leaves it
    wr(20'h0, cmd(8'h90));
    wr(20'h0, cmd(8'h11));
    chk(byp === 1'b1, "R10 90/11 stays bypass", 32'(byp), 1);
    wr(AW'($urandom()), cmd(8'h90));
    wr(AW'($urandom()), {8'h00, 8'h00});
    chk(byp === 1'b0, "R10 exit to read array", 32'(byp), 0);
    wr(20'h0, cmd(8'hA0));
    wr(20'h55555, 16'h1357);
    chk(no_req(), "R10 short program rejected", 32'(prog_req), 0);

    // random standard programs with noise writes between
    for (int i = 0; i < 40; i++) begin
      a = AW'($urandom());
      d = DW'($urandom());
      if ($urandom_range(0, 1) == 1) begin
        wr(20'h0, cmd(8'hF0));
        chk(no_req(), "R6 F0 idle", 32'(prog_req), 0);
      end
      unlock();
      wr(AW'($urandom()), cmd(8'hA0));
      wr(a, d);
      chk_prog("R2 random program", a, d);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule